// File: doc/BRIEF.md
# Flash Protected Range Checker

This block sits in front of a serial flash sequencer and judges every access request against a small bank of protected-range entries before the sequencer may start a cycle. Each entry names a window of flash in 4 KiB pages. The window runs from a first page to a last page, and both pages belong to it. Each entry carries its own read-guard and write-guard enables. Firmware programs the entries through a simple word-wide write port and can read any entry back. When firmware asserts the lock input, the entries freeze until the next reset.

A request carries a byte address, a byte count minus one, and a direction flag. An erase is presented as a write. One clock after the request, the block returns a response strobe with an allow or deny verdict. Every denial also raises a sticky access-error flag. This flag is separate from any cycle error that the sequencer itself reports. The flag stays set until the error-clear input is pulsed.

Top module: `prc_top`

## Requirements
- R1: Each entry is a 32-bit word. Bits [13:0] hold the first page (address bits [25:12]) and bits [29:16] hold the last page. Bit 15 is the read-guard enable and bit 31 is the write-guard enable. Bits 14 and 30 are not stored and read back as zero, so writing 0xFFFFFFFF reads back 0xBFFFBFFF.
- R2: A read request (req_write = 0) is denied when any of its bytes falls inside an entry whose read-guard enable is set. The write-guard enable has no effect on reads.
- R3: A write or erase request (req_write = 1) is denied when any of its bytes falls inside an entry whose write-guard enable is set. The read-guard enable has no effect on writes.
- R4: An entry covers the bytes from first_page×4096 up to last_page×4096 + 0xFFF, both ends included. An entry whose first page is above its last page covers nothing.
- R5: An entry with both enables clear never denies a request, whatever its window.
- R6: A request spans the bytes req_addr through req_addr + req_len_m1. An overlap of a single byte at either end is enough to deny it.
- R7: resp_valid is high in exactly the cycle after a cycle with req_valid high. In that cycle resp_allow is 1 for an allowed request and 0 for a denied one. resp_valid is low after an idle cycle.
- R8: A denial sets acc_err in the same cycle that the deny response appears. acc_err then stays set. An allowed request leaves acc_err unchanged.
- R9: A cycle with err_clr high clears acc_err on the next edge. If a denied request is judged in that same cycle, the set wins and acc_err stays 1.
- R10: From the first cycle in which lock_in is high, including that cycle, entry writes are ignored until reset. The existing entries keep enforcing.
- R11: NUM_RANGES (5 or 6) entries sit at consecutive word indices starting at 0. A write to an index at or above NUM_RANGES is ignored, and a read of such an index returns zero.
- R12: After reset all entries are zero, the lock is released, resp_valid is low and acc_err is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | 3 | Entry index for write and read-back |
| cfg_wdata | input | 32 | Entry write word |
| cfg_rdata | output | 32 | Read-back of the entry at cfg_idx |
| lock_in | input | 1 | Freezes the entries until reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 26 | Request start byte address |
| req_len_m1 | input | 6 | Request byte count minus one |
| req_write | input | 1 | 1 for write or erase, 0 for read |
| err_clr | input | 1 | Clears acc_err (write-1-to-clear) |
| resp_valid | output | 1 | Verdict strobe, one cycle after the request |
| resp_allow | output | 1 | 1 when the request may proceed |
| acc_err | output | 1 | Sticky access-error flag |

## Verification
Two pairs of functions can meet in the same cycle. The first pair is the error clear and the judging of a denied request. The bench raises err_clr in the very cycle that a denied request is presented and expects acc_err to remain set. It then pairs err_clr with an allowed request and expects acc_err to drop. The second pair is an entry write and the raising of lock_in. The bench drives them together and expects the written entry to read back unchanged and to keep denying accesses.

// File: rtl/prc_pkg.sv
package prc_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam int PG_W       = 14;
    localparam int ADDR_W     = PG_W + PAGE_SHIFT;
    localparam int WORD_W     = 32;
    localparam int LIMIT_LSB  = 16;
    localparam int RD_EN_BIT  = 15;
    localparam int WR_EN_BIT  = 31;

    typedef logic [PG_W-1:0] page_t;
    typedef logic [PG_W:0]   page_x_t;   // carries the overflow of the end address

    typedef struct packed {
        logic  wr_en;
        page_t last;
        logic  rd_en;
        page_t first;
    } range_t;

    localparam int RANGE_W = $bits(range_t);

    function automatic range_t word_to_range(input logic [WORD_W-1:0] w);
        range_t r;
        r.first = w[PG_W-1:0];
        r.rd_en = w[RD_EN_BIT];
        r.last  = w[LIMIT_LSB+PG_W-1:LIMIT_LSB];
        r.wr_en = w[WR_EN_BIT];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] range_to_word(input range_t r);
        logic [WORD_W-1:0] w;
        w = '0;
        w[PG_W-1:0]                 = r.first;
        w[RD_EN_BIT]                = r.rd_en;
        w[LIMIT_LSB+PG_W-1:LIMIT_LSB] = r.last;
        w[WR_EN_BIT]                = r.wr_en;
        return w;
    endfunction

    // True when the page span [lo, hi] shares at least one page with the entry window.
    function automatic logic span_overlaps(input range_t r, input page_t lo, input page_x_t hi);
        return (r.first <= r.last) && (lo <= r.last) && (hi >= {1'b0, r.first});
    endfunction
endpackage

// File: rtl/prc_range_regs.sv
module prc_range_regs
    import prc_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int IDX_W      = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic [WORD_W-1:0]            cfg_wdata,
    input  logic                         lock_in,
    output logic [WORD_W-1:0]            cfg_rdata,
    output logic                         lock_state,
    output range_t [NUM_RANGES-1:0]      ranges
);
    logic   lock_q;
    logic   write_ok;
    range_t store [NUM_RANGES];

    assign write_ok   = cfg_we && !lock_q && !lock_in;
    assign lock_state = lock_q;

    always_ff @(posedge clk) begin
        if (rst) lock_q <= 1'b0;
        else     lock_q <= lock_q | lock_in;
    end

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                store[g] <= '0;
            else if (write_ok && (cfg_idx == IDX_W'(g)))
                store[g] <= word_to_range(cfg_wdata);
        end
        assign ranges[g] = store[g];
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (cfg_idx == IDX_W'(i)) cfg_rdata = range_to_word(store[i]);
        end
    end
endmodule

// File: rtl/prc_range_match.sv
module prc_range_match
    import prc_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int LEN_W      = 6
) (
    input  range_t [NUM_RANGES-1:0] ranges,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LEN_W-1:0]        req_len_m1,
    input  logic                    req_write,
    output logic                    deny
);
    logic [ADDR_W:0]         end_addr;
    page_t                   lo_page;
    page_x_t                 hi_page;
    logic [NUM_RANGES-1:0]   rd_hit;
    logic [NUM_RANGES-1:0]   wr_hit;

    assign end_addr = {1'b0, req_addr} + {{(ADDR_W+1-LEN_W){1'b0}}, req_len_m1};
    assign lo_page  = req_addr[ADDR_W-1:PAGE_SHIFT];
    assign hi_page  = end_addr[ADDR_W:PAGE_SHIFT];

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
        logic hit;
        assign hit       = span_overlaps(ranges[g], lo_page, hi_page);
        assign rd_hit[g] = hit && ranges[g].rd_en;
        assign wr_hit[g] = hit && ranges[g].wr_en;
    end

    assign deny = req_write ? (|wr_hit) : (|rd_hit);
endmodule

// File: rtl/prc_decide.sv
module prc_decide (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic deny,
    input  logic err_clr,
    output logic resp_valid,
    output logic resp_allow,
    output logic acc_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
            acc_err    <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_allow <= req_valid && !deny;
            acc_err    <= (req_valid && deny) || (acc_err && !err_clr);
        end
    end
endmodule

// File: rtl/prc_top.sv
module prc_top
    import prc_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int LEN_W      = 6,
    localparam int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic [WORD_W-1:0]    cfg_rdata,
    input  logic                 lock_in,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len_m1,
    input  logic                 req_write,
    input  logic                 err_clr,
    output logic                 resp_valid,
    output logic                 resp_allow,
    output logic                 acc_err
);
    range_t [NUM_RANGES-1:0] ranges;
    logic                    lock_state;
    logic                    deny;

    prc_range_regs #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .lock_in    (lock_in),
        .cfg_rdata  (cfg_rdata),
        .lock_state (lock_state),
        .ranges     (ranges)
    );

    prc_range_match #(.NUM_RANGES(NUM_RANGES), .LEN_W(LEN_W)) u_match (
        .ranges     (ranges),
        .req_addr   (req_addr),
        .req_len_m1 (req_len_m1),
        .req_write  (req_write),
        .deny       (deny)
    );

    prc_decide u_decide (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .deny       (deny),
        .err_clr    (err_clr),
        .resp_valid (resp_valid),
        .resp_allow (resp_allow),
        .acc_err    (acc_err)
    );
endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
    parameter int NUM_RANGES = 5,
    parameter int RANGE_W    = 30
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          req_valid,
    input logic                          err_clr,
    input logic                          resp_valid,
    input logic                          resp_allow,
    input logic                          acc_err,
    input logic                          lock_state,
    input logic [NUM_RANGES*RANGE_W-1:0] ranges_flat
);
    a_r7_resp_after_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    a_r7_idle_no_resp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    a_r8_deny_flags_err: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_allow) |-> acc_err);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (acc_err && !err_clr) |=> acc_err);

    a_r9_clear_unless_deny: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> (!acc_err || (resp_valid && !resp_allow)));

    a_r10_entries_frozen: assert property (@(posedge clk) disable iff (rst)
        lock_state |=> $stable(ranges_flat));

    a_r10_lock_holds: assert property (@(posedge clk) disable iff (rst)
        lock_state |=> lock_state);
endmodule

bind prc_top prc_checker #(.NUM_RANGES(NUM_RANGES), .RANGE_W(prc_pkg::RANGE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .err_clr     (err_clr),
    .resp_valid  (resp_valid),
    .resp_allow  (resp_allow),
    .acc_err     (acc_err),
    .lock_state  (lock_state),
    .ranges_flat (ranges)
);

// File: tb/tb_prc_top.sv
module tb_prc_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        lock_in;
    logic        req_valid;
    logic [25:0] req_addr;
    logic [5:0]  req_len_m1;
    logic        req_write;
    logic        err_clr;
    logic        resp_valid;
    logic        resp_allow;
    logic        acc_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    prc_top dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lock_in(lock_in),
        .req_valid(req_valid), .req_addr(req_addr), .req_len_m1(req_len_m1),
        .req_write(req_write), .err_clr(err_clr), .resp_valid(resp_valid),
        .resp_allow(resp_allow), .acc_err(acc_err)
    );

    // {addr, len_m1, write, expected allow}
    localparam logic [33:0] VECS [0:12] = '{
        {26'h000F000, 6'd63, 1'b0, 1'b1},  // R2 clear of entry 0
        {26'h000FFC0, 6'd63, 1'b0, 1'b1},  // R6 ends on last byte below window
        {26'h000FFF0, 6'd16, 1'b0, 1'b0},  // R6 last byte enters window
        {26'h0010000, 6'd63, 1'b1, 1'b1},  // R3 read-only guard ignores writes
        {26'h001FFFF, 6'd0,  1'b0, 1'b0},  // R4 top byte of last page included
        {26'h0020000, 6'd0,  1'b0, 1'b1},  // R4 first byte above window
        {26'h0100FFF, 6'd0,  1'b1, 1'b0},  // R3 write into write guard
        {26'h0100000, 6'd63, 1'b0, 1'b1},  // R2 write guard ignores reads
        {26'h00FFFFF, 6'd1,  1'b1, 1'b0},  // R6 first byte below, second inside
        {26'h0200000, 6'd63, 1'b1, 1'b1},  // R5 entry with no enables
        {26'h02F8000, 6'd0,  1'b1, 1'b1},  // R4 inverted entry covers nothing
        {26'h3FFFFFF, 6'd0,  1'b0, 1'b0},  // R4 topmost page
        {26'h00FFFC0, 6'd63, 1'b1, 1'b1}   // R6 ends just below write guard
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] idx, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] idx, output logic [31:0] w);
        cfg_idx = idx;
        #1;
        w = cfg_rdata;
    endtask

    task automatic issue(input logic [25:0] a, input logic [5:0] l, input logic wr, input logic clr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len_m1 = l; req_write = wr; err_clr = clr;
        @(negedge clk);
        req_valid = 1'b0; err_clr = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        cfg_we = 0; cfg_idx = 0; cfg_wdata = 0; lock_in = 0;
        req_valid = 0; req_addr = 0; req_len_m1 = 0; req_write = 0; err_clr = 0;
        do_reset();

        // R12 reset state
        check("R12 resp_valid", {31'd0, resp_valid}, 32'd0);
        check("R12 acc_err", {31'd0, acc_err}, 32'd0);
        cfg_read(3'd0, rd);
        check("R12 entry0", rd, 32'h0);

        // R1 reserved bits
        cfg_write(3'd2, 32'hFFFF_FFFF);
        cfg_read(3'd2, rd);
        check("R1 reserved read zero", rd, 32'hBFFF_BFFF);

        // R11 out-of-range index
        cfg_write(3'd5, 32'hFFFF_FFFF);
        cfg_read(3'd5, rd);
        check("R11 index 5", rd, 32'h0);
        cfg_read(3'd7, rd);
        check("R11 index 7", rd, 32'h0);

        // program the entries
        cfg_write(3'd0, 32'h001F_8010);  // pages 0x10..0x1F read guard
        cfg_write(3'd1, 32'h8100_0100);  // page 0x100 write guard
        cfg_write(3'd2, 32'h02FF_0200);  // no enables
        cfg_write(3'd3, 32'h82F0_8300);  // first > last
        cfg_write(3'd4, 32'hBFFF_BFFF);  // top page, both guards
        cfg_read(3'd0, rd);
        check("R1 entry0 readback", rd, 32'h001F_8010);

        for (int i = 0; i < 13; i++) begin
            issue(VECS[i][33:8], VECS[i][7:2], VECS[i][1], 1'b0);
            check("R7 resp_valid", {31'd0, resp_valid}, 32'd1);
            check($sformatf("R2/R3/R4/R5/R6 vector %0d allow", i), {31'd0, resp_allow}, {31'd0, VECS[i][0]});
            if (!VECS[i][0]) check("R8 deny sets acc_err", {31'd0, acc_err}, 32'd1);
        end

        // R7 idle cycle
        @(negedge clk);
        check("R7 idle no resp", {31'd0, resp_valid}, 32'd0);

        // R9 plain clear
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        check("R9 clear", {31'd0, acc_err}, 32'd0);

        // R8 allowed request leaves flag clear
        issue(26'h0000000, 6'd0, 1'b0, 1'b0);
        check("R8 allow no err", {31'd0, acc_err}, 32'd0);

        // R9 clear and deny in the same cycle: set wins
        issue(26'h0010000, 6'd0, 1'b0, 1'b1);
        check("R9 set wins", {31'd0, acc_err}, 32'd1);
        check("R9 deny verdict", {31'd0, resp_allow}, 32'd0);
        // clear together with an allowed request
        issue(26'h0000000, 6'd0, 1'b0, 1'b1);
        check("R9 clear with allow", {31'd0, acc_err}, 32'd0);

        // R10 write in the same cycle as lock is ignored
        @(negedge clk);
        lock_in = 1'b1; cfg_we = 1'b1; cfg_idx = 3'd1; cfg_wdata = 32'h0;
        @(negedge clk);
        lock_in = 1'b0; cfg_we = 1'b0;
        cfg_read(3'd1, rd);
        check("R10 same-cycle write ignored", rd, 32'h8100_0100);
        cfg_write(3'd1, 32'h0);
        cfg_read(3'd1, rd);
        check("R10 later write ignored", rd, 32'h8100_0100);
        issue(26'h0100000, 6'd0, 1'b1, 1'b0);
        check("R10 still enforced", {31'd0, resp_allow}, 32'd0);

        // R12 reset releases lock and clears entries
        do_reset();
        cfg_read(3'd1, rd);
        check("R12 entry cleared", rd, 32'h0);
        check("R12 acc_err cleared", {31'd0, acc_err}, 32'd0);
        cfg_write(3'd1, 32'h8100_0100);
        cfg_read(3'd1, rd);
        check("R10 lock released", rd, 32'h8100_0100);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule